// File: doc/BRIEF.md
# Readout Frame Lane Serializer and Deserializer

The block carries a wide readout record across a narrow parallel link. When the record for one accepted event is captured, it is split into twelve slices of seven bits. Each slice goes out on its own data lane of a 20-bit link word, one bit per clock with the most significant bit first, so the whole 84-bit record crosses in seven clocks. A framing bit in the top position of the link word stays high for exactly the clocks that carry frame data. The receiver uses it to align, and it ignores the data lanes whenever it is low.

The transmit side holds one capture beyond the frame in flight. When a frame ends it starts the held frame on the very next clock, so consecutive frames leave no idle gap. A request that finds both the shifter and the holding slot occupied is dropped and reported on an overflow pulse. The receive side rebuilds the record from the lane bitstreams and presents it with a one-cycle valid strobe. Its input is a separate port, so the two halves can sit at opposite ends of a link or be looped back.

Top module: `readout_frame_link`

## Requirements
- R1: While rst_ni is low and after it is released with no capture, busy_o, overflow_o and rx_valid_o are 0 and every bit of link_o is 0.
- R2: A capture while busy_o is 0 starts a frame on the next cycle. The framing bit link_o[19] is then high for exactly 7 consecutive cycles per frame.
- R3: During a frame, data lane k (link_o[k], k = 0..11) carries record bits [7k+6:7k] serially, starting with bit 7k+6 and ending with bit 7k.
- R4: link_o[18:12] are always 0, and link_o[11:0] are 0 in every cycle in which link_o[19] is 0.
- R5: busy_o is 1 exactly in the cycles in which a frame is on the link.
- R6: A capture during a frame is held in a one-deep slot. The held frame starts in the cycle right after the last bit of the current one, so link_o[19] stays high for 14 consecutive cycles.
- R7: A capture that arrives while the slot is occupied and the current frame is not in its last bit cycle is discarded. overflow_o is then 1 for one cycle, in the cycle after that capture, and the frames already accepted go out unchanged.
- R8: A capture in the last bit cycle of a frame while the slot is occupied is accepted without overflow. The held frame goes out next, and the new capture takes the slot.
- R9: After rx_link_i[19] has been high for 7 consecutive cycles, rx_valid_o is 1 for one cycle on the following cycle, with rx_record_o equal to the transmitted record.
- R10: While rx_link_i[19] is 0, the receiver discards the values on rx_link_i[11:0] and does not assert rx_valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| capture_i | input | 1 | Capture strobe for record_i |
| record_i | input | 84 | Readout record to send |
| busy_o | output | 1 | A frame is on the link |
| overflow_o | output | 1 | One-cycle pulse: a capture was discarded |
| link_o | output | 20 | Link word: lanes 0..11 data, 12..18 zero, 19 framing |
| rx_link_i | input | 20 | Received link word, same layout |
| rx_record_o | output | 84 | Rebuilt record |
| rx_valid_o | output | 1 | One-cycle strobe for rx_record_o |

## Verification
The bench builds the block with its default parameters: twelve lanes of seven bits, an 84-bit record and a 20-bit link word. At this size every lane position, the spare lanes and the framing bit can be seen directly at the ports. Captures are spaced randomly, so single frames, back-to-back pairs, slot replacement in the last bit cycle and discarded third requests all occur. Junk is placed on the receive data lanes between frames to show that the receiver discards it.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/rfl_pending_slot.sv
module rfl_pending_slot #(
  parameter int unsigned W = 84
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         drop_o
);
  logic         valid_q;
  logic [W-1:0] data_q;
  logic         take;

  // occupied and not draining this cycle: request lost
  assign drop_o = push_i && valid_q && !pop_i;
  assign take   = push_i && !drop_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        data_q  <= data_i;
      end else if (pop_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/rfl_lane_tx.sv
module rfl_lane_tx
  import rfl_pkg::*;
#(
  parameter int unsigned N_LANES   = 12,
  parameter int unsigned FRAME_LEN = 7,
  localparam int unsigned REC_W    = N_LANES * FRAME_LEN,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [REC_W-1:0]   rec_i,
  output logic               active_o,
  output logic               last_o,
  output logic [N_LANES-1:0] bits_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(FRAME_LEN - 1);

  tx_state_e                         state_q;
  logic [CNT_W-1:0]                  cnt_q;
  logic [N_LANES-1:0][FRAME_LEN-1:0] sh_q;

  assign active_o = (state_q == TX_SEND);
  assign last_o   = active_o && (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (load_i) begin
      state_q <= TX_SEND;
      cnt_q   <= '0;
      for (int k = 0; k < N_LANES; k++) sh_q[k] <= rec_i[k*FRAME_LEN +: FRAME_LEN];
    end else if (active_o) begin
      if (last_o) begin
        state_q <= TX_IDLE;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        for (int k = 0; k < N_LANES; k++) sh_q[k] <= {sh_q[k][FRAME_LEN-2:0], 1'b0};
      end
    end
  end

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    assign bits_o[k] = active_o & sh_q[k][FRAME_LEN-1];
  end
endmodule

// File: rtl/rfl_lane_rx.sv
module rfl_lane_rx #(
  parameter int unsigned N_LANES   = 12,
  parameter int unsigned FRAME_LEN = 7,
  localparam int unsigned REC_W    = N_LANES * FRAME_LEN,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               dav_i,
  input  logic [N_LANES-1:0] bits_i,
  output logic [REC_W-1:0]   rec_o,
  output logic               valid_o
);
  localparam logic [CNT_W-1:0] LastCnt = CNT_W'(FRAME_LEN - 1);

  logic [CNT_W-1:0]                  cnt_q;
  logic [N_LANES-1:0][FRAME_LEN-1:0] sh_q;
  logic [N_LANES-1:0][FRAME_LEN-1:0] sh_d;
  logic [REC_W-1:0]                  rec_q;
  logic                              valid_q;

  for (genvar k = 0; k < N_LANES; k++) begin : g_lane
    assign sh_d[k] = {sh_q[k][FRAME_LEN-2:0], bits_i[k]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      rec_q   <= '0;
      valid_q <= 1'b0;
    end else if (dav_i) begin
      sh_q <= sh_d;
      if (cnt_q == LastCnt) begin
        cnt_q   <= '0;
        valid_q <= 1'b1;
        for (int k = 0; k < N_LANES; k++) rec_q[k*FRAME_LEN +: FRAME_LEN] <= sh_d[k];
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        valid_q <= 1'b0;
      end
    end else begin
      // framing low: drop any partial frame, lanes are not sampled
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end
  end

  assign rec_o   = rec_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/readout_frame_link.sv
module readout_frame_link #(
  parameter int unsigned N_LANES   = 12,
  parameter int unsigned FRAME_LEN = 7,
  parameter int unsigned LINK_W    = 20,
  localparam int unsigned REC_W    = N_LANES * FRAME_LEN,
  localparam int unsigned DAV_BIT  = LINK_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [REC_W-1:0]  record_i,
  output logic              busy_o,
  output logic              overflow_o,
  output logic [LINK_W-1:0] link_o,
  input  logic [LINK_W-1:0] rx_link_i,
  output logic [REC_W-1:0]  rx_record_o,
  output logic              rx_valid_o
);
  logic               tx_active, tx_last, tx_ready, tx_load;
  logic [N_LANES-1:0] tx_bits;
  logic [REC_W-1:0]   load_rec;
  logic               pend_valid, pend_push, pend_pop, pend_drop;
  logic [REC_W-1:0]   pend_data;
  logic               ovf_q;

  assign tx_ready  = !tx_active || tx_last;
  assign pend_pop  = tx_ready && pend_valid;
  // direct path only when shifter free and nothing held
  assign pend_push = capture_i && !(tx_ready && !pend_valid);
  assign tx_load   = tx_ready && (pend_valid || capture_i);
  assign load_rec  = pend_valid ? pend_data : record_i;

  rfl_pending_slot #(.W(REC_W)) slot_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (pend_push),
    .pop_i   (pend_pop),
    .data_i  (record_i),
    .valid_o (pend_valid),
    .data_o  (pend_data),
    .drop_o  (pend_drop)
  );

  rfl_lane_tx #(.N_LANES(N_LANES), .FRAME_LEN(FRAME_LEN)) tx_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tx_load),
    .rec_i    (load_rec),
    .active_o (tx_active),
    .last_o   (tx_last),
    .bits_o   (tx_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= pend_drop;
  end

  assign busy_o     = tx_active;
  assign overflow_o = ovf_q;

  assign link_o[N_LANES-1:0] = tx_bits;
  assign link_o[DAV_BIT]     = tx_active;
  if (DAV_BIT > N_LANES) begin : g_spare
    assign link_o[DAV_BIT-1:N_LANES] = '0;
  end

  if (DAV_BIT > N_LANES) begin : g_rx_spare
    logic rx_spare_unused;
    assign rx_spare_unused = ^rx_link_i[DAV_BIT-1:N_LANES];
  end

  rfl_lane_rx #(.N_LANES(N_LANES), .FRAME_LEN(FRAME_LEN)) rx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dav_i   (rx_link_i[DAV_BIT]),
    .bits_i  (rx_link_i[N_LANES-1:0]),
    .rec_o   (rx_record_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
  parameter int unsigned N_LANES   = 12,
  parameter int unsigned FRAME_LEN = 7,
  parameter int unsigned LINK_W    = 20,
  localparam int unsigned DAV_BIT  = LINK_W - 1,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              capture_i,
  input logic              busy_o,
  input logic              overflow_o,
  input logic [LINK_W-1:0] link_o,
  input logic [LINK_W-1:0] rx_link_i,
  input logic              rx_valid_o
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (!link_o[DAV_BIT]) run_q <= '0;
    else if (run_q == CNT_W'(FRAME_LEN - 1)) run_q <= '0;
    else                       run_q <= run_q + 1'b1;
  end

  // R2
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(link_o[DAV_BIT]) |-> run_q == '0);

  // R2
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !busy_o) |=> link_o[DAV_BIT]);

  // R4
  idle_lanes_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_o[DAV_BIT] |-> link_o == '0);

  // R4
  spare_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o[DAV_BIT-1:N_LANES] == '0);

  // R5
  busy_dav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == link_o[DAV_BIT]);

  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(capture_i) && $past(busy_o));

  // R7
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> busy_o);

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R10
  rx_valid_dav_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(rx_link_i[DAV_BIT]));
endmodule

bind readout_frame_link rfl_checker #(
  .N_LANES(N_LANES), .FRAME_LEN(FRAME_LEN), .LINK_W(LINK_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .capture_i  (capture_i),
  .busy_o     (busy_o),
  .overflow_o (overflow_o),
  .link_o     (link_o),
  .rx_link_i  (rx_link_i),
  .rx_valid_o (rx_valid_o)
);

// File: tb/readout_frame_link_tb_top.sv
module readout_frame_link_tb_top;
  localparam int NL = 12;
  localparam int FL = 7;
  localparam int LW = 20;
  localparam int RW = NL * FL;
  localparam int DAV = LW - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          capture = 1'b0;
  logic [RW-1:0] record = '0;
  logic          busy, ovf, rx_valid;
  logic [LW-1:0] link, rx_link;
  logic [RW-1:0] rx_record;
  logic          inj_en = 1'b0;
  logic [LW-1:0] inj_val = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // model state
  bit          m_act = 0, m_pend = 0, m_ovf = 0, m_vnext = 0;
  int          m_cnt = 0;
  logic [RW-1:0] m_cur = '0, m_pdat = '0;
  logic [RW-1:0] exp_q[$];

  always #10 clk = ~clk;

  assign rx_link = (inj_en && !link[DAV]) ? inj_val : link;

  readout_frame_link dut_i (
    .clk_i(clk), .rst_ni(rst_n), .capture_i(capture), .record_i(record),
    .busy_o(busy), .overflow_o(ovf), .link_o(link), .rx_link_i(rx_link),
    .rx_record_o(rx_record), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] rnd_rec();
    return RW'({$urandom(), $urandom(), $urandom()});
  endfunction

  function automatic logic [NL-1:0] exp_lanes(input logic [RW-1:0] r, input int c);
    logic [NL-1:0] v;
    for (int k = 0; k < NL; k++) v[k] = r[k*FL + FL-1 - c];
    return v;
  endfunction

  // at a negedge: check outputs against model, apply inputs, advance model
  task automatic step(input bit c, input logic [RW-1:0] r, input bit inj);
    bit last, ready, ovf_n;
    chk(busy == m_act, "R5 busy", 96'(busy), 96'(m_act));
    chk(link[DAV] == m_act, "R2 R6 framing", 96'(link[DAV]), 96'(m_act));
    chk(link[DAV-1:NL] == '0, "R4 spare", 96'(link[DAV-1:NL]), 96'(0));
    chk(link[NL-1:0] == (m_act ? exp_lanes(m_cur, m_cnt) : '0), "R3 R4 lanes",
        96'(link[NL-1:0]), 96'(m_act ? exp_lanes(m_cur, m_cnt) : '0));
    chk(ovf == m_ovf, "R7 R8 overflow", 96'(ovf), 96'(m_ovf));
    chk(rx_valid == m_vnext, "R9 R10 valid", 96'(rx_valid), 96'(m_vnext));
    if (rx_valid) begin
      if (exp_q.size() == 0) chk(0, "R10 spurious", 96'(rx_record), 96'(0));
      else begin
        logic [RW-1:0] e = exp_q.pop_front();
        chk(rx_record == e, "R9 record", 96'(rx_record), 96'(e));
      end
    end
    m_vnext = m_act && (m_cnt == FL-1);
    capture = c;
    record  = r;
    inj_en  = inj;
    inj_val = {1'b0, LW'($urandom()) & ((LW'(1) << (LW-1)) - 1)};
    last  = m_act && (m_cnt == FL-1);
    ready = !m_act || last;
    ovf_n = 0;
    if (ready) begin
      if (m_pend) begin
        m_cur = m_pdat; m_act = 1; m_cnt = 0;
        if (c) m_pdat = r; else m_pend = 0;
      end else if (c) begin
        m_cur = r; m_act = 1; m_cnt = 0;
      end else begin
        m_act = 0; m_cnt = 0;
      end
    end else begin
      m_cnt++;
      if (c) begin
        if (!m_pend) begin m_pend = 1; m_pdat = r; end
        else ovf_n = 1;
      end
    end
    if (c && !ovf_n) exp_q.push_back(r);
    m_ovf = ovf_n;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #25;
    // R1: reset values
    chk(busy == 0 && ovf == 0 && rx_valid == 0 && link == '0, "R1 reset",
        96'({busy, ovf, rx_valid, link}), 96'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle(3);
    // single frame with known pattern
    step(1, RW'(96'h0123_4567_89ab_cdef_0f1e_2d3c), 0);
    idle(12);
    // back to back: R6
    step(1, rnd_rec(), 0);
    step(1, rnd_rec(), 0);
    idle(20);
    // third request while slot full: R7
    step(1, rnd_rec(), 0);
    step(1, rnd_rec(), 0);
    step(1, rnd_rec(), 0);
    idle(25);
    // slot full and capture on last bit cycle: R8
    step(1, rnd_rec(), 0);
    step(1, rnd_rec(), 0);
    while (!(m_act && m_cnt == FL-1)) step(0, '0, 0);
    step(1, rnd_rec(), 0);
    chk(m_ovf == 0 && m_pend == 1, "R8 model", 96'(m_ovf), 96'(0));
    idle(30);
    // junk on receive lanes while framing low: R10
    idle(40);
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit c = ($urandom_range(0, 5) == 0);
      step(c, rnd_rec(), $urandom_range(0, 1) == 1);
    end
    idle(40);
    chk(exp_q.size() == 0, "R9 drained", 96'(exp_q.size()), 96'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule